// File: doc/BRIEF.md
# Circular-Buffer Resampling Commutator

This block sits at the input of a polyphase channelizer whose output rate is above the maximally decimated rate. Each block step accepts `L` new samples (default 48) into an `M`-deep circular buffer (default 64), where `L` is smaller than `M`. Successive blocks therefore overlap, and the channelizer produces more output samples per symbol without an interpolator after the filter bank.

Because the buffer advances by `L` rather than `M`, the time origin seen by the sub-filters and the transform slips by `L mod M` every block. The block tracks this slip as a running origin offset. It then streams the whole buffer out, one entry per clock, with the read order rotated by that offset, so that every block reaches the transform with the same phase reference. Samples are stored newest-first at descending addresses to match the commutator direction. A new block is accepted only after the previous read-out has finished, and `in_ready_o` applies back-pressure until then.

`M` must be a power of two. The sub-filter arithmetic and the transform are outside this block.

Top module: `circ_commutator`

## Requirements
- R1: After reset `in_ready_o` is 1, `out_valid_o`, `out_first_o` and `out_last_o` are 0, `out_origin_o` is 0, and every buffer entry reads as zero.
- R2: `in_ready_o` is 1 exactly while the block is collecting input. An `in_valid_i` that is asserted while `in_ready_o` is 0 has no effect on later output data.
- R3: The clock edge that accepts the `L`-th sample of a block starts the read-out. From the next cycle on, `out_valid_o` is 1 for exactly `M` consecutive cycles.
- R4: `out_first_o` is 1 only on read entry 0. `out_last_o` is 1 only on read entry `M-1`. Both are 0 whenever `out_valid_o` is 0.
- R5: Read entry k (k = 0 is the first entry) carries the sample accepted j = (origin + k) mod M acceptances before the newest one, where j = 0 is the newest sample. If fewer than j+1 samples have been accepted since reset, the entry is 0.
- R6: During the fill and read-out of block b (b = 0 is the first block after reset), `out_origin_o` equals (b·L) mod M. With the defaults this gives 0, 48, 32, 16, and the sequence then repeats. The origin advances on the clock edge that ends the read-out.
- R7: `in_ready_o` is 1 again in the cycle right after `out_last_o`.
- R8: Idle cycles between accepted samples change neither the read-out timing relative to the `L`-th acceptance nor its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block is collecting input |
| in_data_i | input | DATA_W | Input sample |
| out_valid_o | output | 1 | Read-out entry valid |
| out_first_o | output | 1 | First entry of a read-out |
| out_last_o | output | 1 | Last entry of a read-out |
| out_data_o | output | DATA_W | Rotated buffer entry |
| out_origin_o | output | $clog2(M_DEPTH) | Origin offset of the current block |

## Verification
A sample is accepted on the rising edge at which `in_valid_i` and `in_ready_o` are both high. The first read entry appears one cycle after the `L`-th acceptance, entry k appears k cycles after that, and `in_ready_o` returns one cycle after the last entry. The origin changes on that same edge. The bench keeps a behavioural model that it updates at each rising edge from the inputs it drove, and it compares every output against the model at the following falling edge. Each result is therefore checked in the first cycle in which it is due. Inputs are driven on falling edges, including junk samples offered while `in_ready_o` is low.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_READ = 1'b1
  } phase_e;
endpackage

// File: rtl/cc_wr_ctrl.sv
module cc_wr_ctrl #(
  parameter int M_DEPTH = 64,
  parameter int L_STEP  = 48,
  localparam int AW = $clog2(M_DEPTH),
  localparam int CW = $clog2(L_STEP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] newest_o,
  output logic          blk_done_o
);
  localparam logic [CW-1:0] LAST_CNT = CW'(L_STEP - 1);

  logic [AW-1:0] wp_q;
  logic [CW-1:0] cnt_q;

  // descending write pointer, wraps modulo M
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= AW'(M_DEPTH - 1);
      cnt_q <= '0;
    end else if (accept_i) begin
      wp_q  <= wp_q - 1'b1;
      cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
    end
  end

  assign wr_addr_o  = wp_q;
  assign newest_o   = wp_q + 1'b1;
  assign blk_done_o = accept_i && (cnt_q == LAST_CNT);

  // R5
  wp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> wr_addr_o == $past(wr_addr_o) - 1'b1);
endmodule

// File: rtl/cc_buffer.sv
module cc_buffer #(
  parameter int M_DEPTH = 64,
  parameter int DATA_W  = 16,
  localparam int AW = $clog2(M_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [M_DEPTH];

  for (genvar i = 0; i < M_DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (we_i && (waddr_i == AW'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cc_origin.sv
module cc_origin #(
  parameter int M_DEPTH = 64,
  parameter int L_STEP  = 48,
  localparam int AW = $clog2(M_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] origin_o
);
  localparam logic [AW-1:0] STEP = AW'(L_STEP % M_DEPTH);

  logic [AW-1:0] org_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    org_q <= '0;
    else if (adv_i) org_q <= org_q + STEP;
  end

  assign origin_o = org_q;
endmodule

// File: rtl/cc_reader.sv
module cc_reader
  import cc_pkg::*;
#(
  parameter int M_DEPTH = 64,
  localparam int AW = $clog2(M_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_done_i,
  input  logic [AW-1:0] newest_i,
  input  logic [AW-1:0] origin_i,
  output logic          fill_o,
  output logic          valid_o,
  output logic          first_o,
  output logic          last_o,
  output logic          adv_o,
  output logic [AW-1:0] raddr_o
);
  localparam logic [AW-1:0] K_LAST = AW'(M_DEPTH - 1);

  phase_e        ph_q;
  logic [AW-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_FILL;
      k_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_FILL: if (blk_done_i) begin
          ph_q <= PH_READ;
          k_q  <= '0;
        end
        PH_READ: begin
          k_q <= k_q + 1'b1;
          if (k_q == K_LAST) ph_q <= PH_FILL;
        end
        default: ph_q <= PH_FILL;
      endcase
    end
  end

  assign fill_o  = (ph_q == PH_FILL);
  assign valid_o = (ph_q == PH_READ);
  assign first_o = valid_o && (k_q == '0);
  assign last_o  = valid_o && (k_q == K_LAST);
  assign adv_o   = last_o;
  // rotation: newest address plus origin plus entry index
  assign raddr_o = newest_i + origin_i + k_q;

  // R4
  first_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |=> !first_o);
  // R3
  start_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> first_o);
  // R3
  start_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o && blk_done_i) |=> first_o);
endmodule

// File: rtl/circ_commutator.sv
module circ_commutator #(
  parameter int M_DEPTH = 64,
  parameter int L_STEP  = 48,
  parameter int DATA_W  = 16,
  localparam int AW = $clog2(M_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic              out_first_o,
  output logic              out_last_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [AW-1:0]     out_origin_o
);
  logic          accept;
  logic [AW-1:0] wr_addr, newest, raddr, origin;
  logic          blk_done, fill, adv;

  assign accept = in_valid_i && fill;

  cc_wr_ctrl #(.M_DEPTH(M_DEPTH), .L_STEP(L_STEP)) u_wr (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .wr_addr_o  (wr_addr),
    .newest_o   (newest),
    .blk_done_o (blk_done)
  );

  cc_buffer #(.M_DEPTH(M_DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .we_i    (accept),
    .waddr_i (wr_addr),
    .wdata_i (in_data_i),
    .raddr_i (raddr),
    .rdata_o (out_data_o)
  );

  cc_origin #(.M_DEPTH(M_DEPTH), .L_STEP(L_STEP)) u_org (
    .clk_i, .rst_ni,
    .adv_i    (adv),
    .origin_o (origin)
  );

  cc_reader #(.M_DEPTH(M_DEPTH)) u_rd (
    .clk_i, .rst_ni,
    .blk_done_i (blk_done),
    .newest_i   (newest),
    .origin_i   (origin),
    .fill_o     (fill),
    .valid_o    (out_valid_o),
    .first_o    (out_first_o),
    .last_o     (out_last_o),
    .adv_o      (adv),
    .raddr_o    (raddr)
  );

  assign in_ready_o   = fill;
  assign out_origin_o = origin;

  // R7
  ready_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> in_ready_o && !out_valid_o);
  // R6
  origin_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> out_origin_o == $past(out_origin_o) + AW'(L_STEP % M_DEPTH));
  // R6
  origin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(out_last_o) |-> $stable(out_origin_o));
  // R2
  no_write_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> $stable(newest) || !$past(out_valid_o));
endmodule

// File: tb/circ_commutator_test.sv
module circ_commutator_test;
  localparam int M  = 64;
  localparam int L  = 48;
  localparam int DW = 16;
  localparam int AW = $clog2(M);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, out_first, out_last;
  logic [DW-1:0] out_data;
  logic [AW-1:0] out_origin;

  always #10 clk = ~clk;

  circ_commutator #(.M_DEPTH(M), .L_STEP(L), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_first_o(out_first), .out_last_o(out_last),
    .out_data_o(out_data), .out_origin_o(out_origin)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural model
  logic [DW-1:0] hist[$];
  bit m_rd  = 1'b0;
  int m_cnt = 0;
  int m_k   = 0;
  int m_blk = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!m_rd) begin
        if (in_valid) begin
          hist.push_front(in_data);
          if (hist.size() > M) void'(hist.pop_back());
          m_cnt++;
          if (m_cnt == L) begin
            m_rd  = 1'b1;
            m_k   = 0;
            m_cnt = 0;
          end
        end
      end else if (m_k == M - 1) begin
        m_rd = 1'b0;
        m_blk++;
      end else begin
        m_k++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_org;
      int j;
      logic [DW-1:0] exp_d;
      exp_org = (m_blk * L) % M;
      chk(in_ready == !m_rd, "R2/R7 in_ready", in_ready, !m_rd);
      chk(out_valid == m_rd, "R3 out_valid", out_valid, m_rd);
      chk(out_origin == AW'(exp_org), "R6 origin", out_origin, exp_org);
      chk(out_first == (m_rd && m_k == 0), "R4 first", out_first, m_rd && m_k == 0);
      chk(out_last == (m_rd && m_k == M - 1), "R4 last", out_last, m_rd && m_k == M - 1);
      if (m_rd) begin
        j = (exp_org + m_k) % M;
        exp_d = (j < hist.size()) ? hist[j] : '0;
        chk(out_data == exp_d, "R5/R8 data", out_data, exp_d);
      end
    end
  end

  // drive one block's worth of samples; gaps and junk offers while not ready
  task automatic run_samples(input int n, input bit rnd_data, input bit gaps, input int base);
    int sent = 0;
    while (sent < n) begin
      @(negedge clk);
      if (in_ready && !(gaps && ($urandom % 3 == 0))) begin
        in_valid = 1'b1;
        in_data  = rnd_data ? DW'($urandom) : DW'(base + sent);
        sent++;
      end else begin
        // R2: offered while not ready (or idle), must be ignored
        in_valid = !in_ready ? 1'($urandom) : 1'b0;
        in_data  = 16'hDEAD ^ DW'($urandom);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(out_first == 1'b0 && out_last == 1'b0, "R1 strobes", {out_first, out_last}, 0);
    chk(out_origin == '0, "R1 origin", out_origin, 0);
    rst_n = 1'b1;
    // R1/R5: first block reads zero for unwritten entries
    run_samples(L, 1'b0, 1'b0, 16'h0100);
    run_samples(L * 4, 1'b0, 1'b0, 16'h1000);
    // R8: random gaps and junk offers during read-out
    run_samples(L * 6, 1'b1, 1'b1, 0);
    run_samples(L, 1'b0, 1'b1, 16'hFF00);
    repeat (M + 8) @(negedge clk);
    chk(m_blk == 12, "R6 block count", m_blk, 12);
    chk(in_ready == 1'b1, "R7 idle ready", in_ready, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule